// File: doc/BRIEF.md
# Parallel Multi-Byte Signature Matcher

This block scans a byte stream for a fixed set of string signatures. It takes several bytes per clock cycle. Each accepted input word is compared in every byte lane against the characters of every signature. A chain of small processing elements, one for each signature character, then passes lane carries from character to character. A signature is reported when the element for its final character is reached by an unbroken chain. The chain may start in any lane and may run past the end of a word into the next one. Because of this, signatures that overlap, sit next to each other, or repeat inside themselves are all found, at any byte alignment.

The signature set is fixed at elaboration. Each signature occupies one slot of `SIG_TEXT` with its last character in the lowest byte of the slot, and `SIG_LENS` gives its length. Input arrives on a valid/ready stream. For every accepted word, exactly one result word comes out on a second valid/ready stream. That result gives, for each signature, a per-lane vector of where matches ended, plus a one-bit hit flag. Downstream logic turns the lane vectors into end addresses. The block holds partial matches across word boundaries and across idle cycles. Assert `rst` between packets so that a partial match from one packet cannot finish in the next.

Back-pressure works as follows. The block holds one result word. It accepts a new input word only when that slot is empty or is being drained in the same cycle. While the downstream side stalls, `in_ready` stays low. No input is consumed and the held carries do not move.

Top module: `sigscan_top`

## Requirements
- R1: A synchronous `rst` high at a clock edge empties the result slot (`out_valid` low) and clears every stored lane carry. A signature whose bytes straddle the reset is not reported.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A word is taken when `in_valid` and `in_ready` are both high at an edge, and each taken word produces one result word, valid from that edge on.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sig` and `out_lanes` stay unchanged.
- R4: Byte lane j of `in_data` is bits [8j+7:8j], and lane 0 is the earliest byte of the word in stream order.
- R5: A signature that lies entirely inside one word is reported in that word's result, at the lane of its last character. For example, "l44" in the word "fl44" sets lane 3.
- R6: A signature that crosses a word boundary is reported in the result of the word holding its last character, at that character's lane.
- R7: Overlapping and adjacent occurrences of different signatures are all reported. In "AFOOBARCD", both "FOO" and "BAR" are found. In "ABABAR", both "ABAB" and "BAR" are found.
- R8: A signature that overlaps itself is reported once per occurrence. In "ABABAB", "ABAB" ends at stream bytes 3 and 5.
- R9: Result layout: bit `s*LANES+j` of `out_lanes` is set when signature s ended in lane j. `out_sig[s]` is the OR of that signature's lane bits. Signature 0 is "l44", 1 is "FOO", 2 is "BAR" and 3 is "ABAB" by default.
- R10: Cycles with `in_valid` low do not disturb a partial match. The stream continues from the last taken word.
- R11: While `out_valid` is low, `out_sig` and `out_lanes` are all zero.
- R12: A byte sequence that breaks a signature in the middle, such as "FOXO" for "FOO", reports no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; use it between packets |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word |
| in_data | input | LANES*8 | Input bytes, lane 0 in the low byte |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Downstream takes the result word |
| out_sig | output | NUM_SIGS | Per-signature hit flag for the result word |
| out_lanes | output | NUM_SIGS*LANES | Per-signature, per-lane match-end bits |

## Verification
The main function is tried with several kinds of input. A signature placed entirely inside one word checks lane ordering and the combinational chain. Signatures split across a boundary, with and without idle cycles in between, check the stored carry and confirm that it holds. Two different signatures sharing or adjoining bytes, and a signature that repeats into itself, show whether the chain keeps independent paths instead of consuming bytes. Broken sequences, a reset placed mid-signature, and a stalled output port show that false matches do not appear, that nothing carries across the reset, and that stalled words are neither lost nor repeated.

// File: rtl/sigscan_pkg.sv
package sigscan_pkg;
  localparam int SYM_W = 8;
  typedef logic [SYM_W-1:0] sym_t;

  // Byte index in the packed signature text of character pos of signature sig.
  // Each slot is right-justified: the last character sits in the slot's low byte.
  function automatic int sym_index(input int sig, input int pos, input int len,
                                   input int max_len);
    return sig * max_len + (len - 1 - pos);
  endfunction
endpackage

// File: rtl/sigscan_charcmp.sv
module sigscan_charcmp #(
  parameter int LANES = 4,
  parameter logic [7:0] SYM = 8'h00
) (
  input  logic [LANES*8-1:0] word,
  input  logic               take,
  output logic [LANES-1:0]   hit
);
  // One equality comparator per lane for this element's character.
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign hit[j] = take && (word[j*8 +: 8] == SYM);
  end
endmodule

// File: rtl/sigscan_pe.sv
module sigscan_pe #(
  parameter int LANES = 4,
  parameter bit BEG = 1'b0,
  parameter bit FIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [LANES-1:0] char_hit,
  input  logic [LANES-1:0] prev_cout,
  input  logic             prev_last,
  output logic [LANES-1:0] cout,
  output logic             last_q,
  output logic [LANES-1:0] end_hit
);
  // Lane 0 continues from the previous word through the stored carry.
  assign cout[0] = char_hit[0] && (prev_last || BEG);

  for (genvar j = 1; j < LANES; j++) begin : g_chain
    assign cout[j] = char_hit[j] && (prev_cout[j-1] || BEG);
  end

  if (FIN) begin : g_fin
    assign end_hit = cout;
  end else begin : g_mid
    assign end_hit = '0;
  end

  // Only the final-lane carry is stored, and only on a taken word.
  always_ff @(posedge clk) begin
    if (rst)       last_q <= 1'b0;
    else if (take) last_q <= cout[LANES-1];
  end
endmodule

// File: rtl/sigscan_hitreg.sv
module sigscan_hitreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         take,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      q         <= in_valid ? d : '0;
    end
  end
endmodule

// File: rtl/sigscan_top.sv
module sigscan_top #(
  parameter int LANES    = 4,
  parameter int NUM_SIGS = 4,
  parameter int MAX_LEN  = 4,
  parameter logic [NUM_SIGS*MAX_LEN*8-1:0] SIG_TEXT =
    {"ABAB", 8'h00, "BAR", 8'h00, "FOO", 8'h00, "l44"},
  parameter logic [NUM_SIGS*8-1:0] SIG_LENS = {8'd4, 8'd3, 8'd3, 8'd3}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*8-1:0]        in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NUM_SIGS-1:0]       out_sig,
  output logic [NUM_SIGS*LANES-1:0] out_lanes
);
  localparam int HITS_W = NUM_SIGS * LANES;
  localparam int RES_W  = HITS_W + NUM_SIGS;

  logic                take;
  logic [LANES-1:0]    cout_a [NUM_SIGS][MAX_LEN];
  logic                last_a [NUM_SIGS][MAX_LEN];
  logic [LANES-1:0]    endh_a [NUM_SIGS][MAX_LEN];
  logic [HITS_W-1:0]   hits_now;
  logic [NUM_SIGS-1:0] sig_now;
  logic [RES_W-1:0]    res_q;

  for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig
    localparam int LEN = int'(SIG_LENS[s*8 +: 8]);
    for (genvar k = 0; k < MAX_LEN; k++) begin : g_ch
      if (k < LEN) begin : g_pe
        localparam logic [7:0] SYM =
          SIG_TEXT[sigscan_pkg::sym_index(s, k, LEN, MAX_LEN)*8 +: 8];
        logic [LANES-1:0] ch_hit;
        logic [LANES-1:0] pc;
        logic             pl;
        if (k == 0) begin : g_head
          assign pc = '0;
          assign pl = 1'b0;
        end else begin : g_link
          assign pc = cout_a[s][k-1];
          assign pl = last_a[s][k-1];
        end
        sigscan_charcmp #(.LANES(LANES), .SYM(SYM)) u_cmp (
          .word(in_data), .take(take), .hit(ch_hit)
        );
        sigscan_pe #(.LANES(LANES), .BEG(k == 0), .FIN(k == LEN - 1)) u_pe (
          .clk(clk), .rst(rst), .take(take), .char_hit(ch_hit),
          .prev_cout(pc), .prev_last(pl), .cout(cout_a[s][k]),
          .last_q(last_a[s][k]), .end_hit(endh_a[s][k])
        );
      end else begin : g_pad
        assign cout_a[s][k] = '0;
        assign last_a[s][k] = 1'b0;
        assign endh_a[s][k] = '0;
      end
    end
  end

  always_comb begin
    hits_now = '0;
    sig_now  = '0;
    for (int s = 0; s < NUM_SIGS; s++) begin
      for (int k = 0; k < MAX_LEN; k++) begin
        hits_now[s*LANES +: LANES] = hits_now[s*LANES +: LANES] | endh_a[s][k];
      end
      sig_now[s] = |hits_now[s*LANES +: LANES];
    end
  end

  sigscan_hitreg #(.W(RES_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .take(take), .d({sig_now, hits_now}), .out_valid(out_valid),
    .out_ready(out_ready), .q(res_q)
  );

  assign out_lanes = res_q[HITS_W-1:0];
  assign out_sig   = res_q[RES_W-1:HITS_W];
endmodule

// File: rtl/sigscan_chk.sv
module sigscan_chk #(
  parameter int LANES    = 4,
  parameter int NUM_SIGS = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [NUM_SIGS-1:0]       out_sig,
  input logic [NUM_SIGS*LANES-1:0] out_lanes
);
  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !out_valid); // R1

  AST_TAKE_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R2

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_lanes) && $stable(out_sig)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_lanes == '0 && out_sig == '0); // R11

  for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig
    AST_FLAG_MATCHES_LANES: assert property (@(posedge clk) disable iff (rst)
      out_sig[s] == (|out_lanes[s*LANES +: LANES])); // R9
  end
endmodule

bind sigscan_top sigscan_chk #(.LANES(LANES), .NUM_SIGS(NUM_SIGS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sig(out_sig),
  .out_lanes(out_lanes)
);

// File: tb/sim_sigscan_top.sv
module sim_sigscan_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_sig;
  logic [15:0] out_lanes;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sigscan_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_sig(out_sig), .out_lanes(out_lanes)
  );

  function automatic logic [31:0] pk(input string s);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = s[i];
    return r;
  endfunction

  function automatic logic [3:0] flags(input logic [15:0] l);
    logic [3:0] r;
    for (int s = 0; s < 4; s++) r[s] = |l[s*4 +: 4];
    return r;
  endfunction

  task automatic expect_res(input string req, input logic v, input logic [15:0] l);
    logic [20:0] act = {out_valid, out_sig, out_lanes};
    logic [20:0] exp = {v, flags(l), l};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s valid/sig/lanes actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic beat(input string w);
    in_valid = 1'b1;
    in_data  = pk(w);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_res("R1 R11 reset state", 1'b0, 16'h0000);
    expect_bit("R2 ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_single();
    do_reset();
    beat("fl44");
    expect_res("R5 R4 R9 l44 inside word", 1'b1, 16'h0008);
  endtask

  task automatic t_neighbours();
    do_reset();
    beat("AFOO"); expect_res("R7 FOO before BAR", 1'b1, 16'h0080);
    beat("BARC"); expect_res("R7 BAR after FOO", 1'b1, 16'h0400);
    beat("D..."); expect_res("R7 tail", 1'b1, 16'h0000);
  endtask

  task automatic t_overlap();
    do_reset();
    beat("ABAB"); expect_res("R7 ABAB first", 1'b1, 16'h8000);
    beat("AR.."); expect_res("R7 R6 BAR sharing B", 1'b1, 16'h0200);
  endtask

  task automatic t_self();
    do_reset();
    beat("ABAB"); expect_res("R8 ABAB first", 1'b1, 16'h8000);
    beat("AB.."); expect_res("R8 ABAB repeat", 1'b1, 16'h2000);
  endtask

  task automatic t_cross();
    do_reset();
    beat("l44F"); expect_res("R6 l44 lane2", 1'b1, 16'h0004);
    beat("OO.."); expect_res("R6 FOO across boundary", 1'b1, 16'h0020);
  endtask

  task automatic t_gap();
    do_reset();
    beat("...F"); expect_res("R10 start", 1'b1, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_res("R11 R10 idle", 1'b0, 16'h0000);
    end
    beat("OO.."); expect_res("R10 FOO after gap", 1'b1, 16'h0020);
  endtask

  task automatic t_broken();
    do_reset();
    beat("FOXO"); expect_res("R12 broken FOO", 1'b1, 16'h0000);
    beat("BA.R"); expect_res("R12 broken BAR", 1'b1, 16'h0000);
    beat("..FO");
    do_reset();
    beat("O..."); expect_res("R1 no carry across reset", 1'b1, 16'h0000);
  endtask

  task automatic t_stall();
    do_reset();
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = pk("fl44");
    @(negedge clk);
    in_data = pk("BARx");
    for (int i = 0; i < 3; i++) begin
      expect_res("R3 held result", 1'b1, 16'h0008);
      expect_bit("R2 ready low while stalled", in_ready, 1'b0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_res("R2 next word after stall", 1'b1, 16'h0400);
    @(negedge clk);
    expect_res("R2 drained", 1'b0, 16'h0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_neighbours();
    t_overlap();
    t_self();
    t_cross();
    t_gap();
    t_broken();
    t_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule